// File: doc/BRIEF.md
# Burst-of-four SRAM core with separate read and write ports

This block is a synchronous on-chip memory with one read port and one write port. It always moves data in bursts of four beats. Each port takes a burst index instead of a word address: the four words of a burst sit at consecutive word addresses, and the block makes the two low address bits itself, counting 0, 1, 2, 3. The double-data-rate pins of a real device are modelled as one beat per cycle of a single fast clock.

A write command carries only the burst index. The four data beats follow in the next four cycles, and each beat carries its own byte enables, so any subset of the bytes in any beat can be updated. A read command returns four beats from a registered output stage two cycles after the command, marked by a valid strobe. Both ports can take a command in the same cycle. A read sees every write accepted in the same cycle or earlier, with bytes merged according to that write's enables, even while the write is still streaming in. A command that arrives while the same port is mid-burst is dropped and reported on that port's error output.

Top module: `sram_b4_core`

## Requirements
- R1: Every accepted read drives `rd_valid` high for exactly four consecutive cycles. Every accepted write consumes exactly the `wr_data`/`wr_be` values of the four cycles that follow the accepting cycle.
- R2: Beat k (k = 0..3) of a burst with index I reads or writes word 4*I + k. Beats are delivered in ascending k order.
- R3: The first read beat is valid in the second cycle after the cycle in which the read command is accepted.
- R4: Data is split into 9-bit bytes, with byte j at bits [9j+8:9j]. `wr_be[j]` is sampled with each data beat. A 1 writes byte j of that beat, and a 0 leaves the stored byte unchanged.
- R5: A read command and a write command can both be accepted in the same cycle, and the two bursts proceed independently.
- R6: A read accepted in the same cycle as a write, or after it, returns that write's new bytes for every enabled byte, including beats that are written while the read burst is in flight.
- R7: A port accepts a command when it is idle or in the cycle of its own fourth beat, so bursts can run back to back with no gap. A command in any other cycle is ignored and does not change memory or the burst in progress.
- R8: An ignored command raises that port's error output (`rd_err` or `wr_err`) for exactly one cycle, the cycle after the command.
- R9: While reset is high, no beat is read or written. After a reset cycle `rd_valid`, `rd_err` and `wr_err` are low, and any burst in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read command |
| rd_idx | input | IDX_W (4) | Burst index of the read |
| wr_req | input | 1 | Write command |
| wr_idx | input | IDX_W (4) | Burst index of the write |
| wr_data | input | DW (18) | Write data beat |
| wr_be | input | BYTES (2) | Byte enables for the current write beat |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DW (18) | Read data beat |
| rd_err | output | 1 | A read command was ignored in the previous cycle |
| wr_err | output | 1 | A write command was ignored in the previous cycle |

## Verification
The assertions check the read timing shape on every cycle: the two-cycle latency, valid runs whose length is a multiple of four, the minimum spacing of accepted commands on each port, the link between an ignored read and a read in progress, and quiet outputs after reset. Data correctness cannot be seen by a property. Only the bench's reference memory can show it: beat addressing, byte masking, same-cycle and in-flight coherence, and the fact that ignored writes leave memory untouched. The bench scenarios also cover back-to-back bursts on both ports and a reset that arrives in the middle of a burst.

// File: rtl/sqb4_pkg.sv
package sqb4_pkg;

    localparam int BYTE_W  = 9;
    localparam int BEAT_W  = 2;
    localparam logic [BEAT_W-1:0] LAST_BEAT = 2'd3;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // choose the freshly written byte over the stored one
    function automatic logic [BYTE_W-1:0] fwd_pick(
        input logic              hit,
        input logic [BYTE_W-1:0] fresh,
        input logic [BYTE_W-1:0] stored
    );
        return hit ? fresh : stored;
    endfunction

endpackage

// File: rtl/sqb4_burst_seq.sv
module sqb4_burst_seq
    import sqb4_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [IDX_W-1:0]   idx,
    output logic               accept,
    output logic               beat_vld,
    output logic [IDX_W+1:0]   beat_word,
    output logic               rej_q
);

    seq_state_e        state_q;
    beat_t             cnt_q;
    logic [IDX_W-1:0]  base_q;
    logic              last_beat;

    assign last_beat = (state_q == SEQ_RUN) && (cnt_q == LAST_BEAT);
    assign accept    = req && ((state_q == SEQ_IDLE) || last_beat);
    assign beat_vld  = (state_q == SEQ_RUN);
    assign beat_word = {base_q, cnt_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            rej_q   <= 1'b0;
        end else begin
            rej_q <= req && !accept;
            if (accept) begin
                state_q <= SEQ_RUN;
                cnt_q   <= '0;
                base_q  <= idx;
            end else if (state_q == SEQ_RUN) begin
                cnt_q <= cnt_q + 2'd1;
                if (last_beat) begin
                    state_q <= SEQ_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/sqb4_lane.sv
module sqb4_lane
    import sqb4_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wd,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rq
);

    localparam int WORDS = 1 << AW;

    logic [BYTE_W-1:0] mem [WORDS];
    logic              same_word;

    assign same_word = we && (waddr == raddr);

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wd;
        end
        if (re) begin
            rq <= fwd_pick(same_word, wd, mem[raddr]);
        end
    end

endmodule

// File: rtl/sram_b4_core.sv
module sram_b4_core
    import sqb4_pkg::*;
#(
    parameter int BYTES = 2,
    parameter int DEPTH = 64,
    localparam int DW    = BYTES * BYTE_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_W = AW - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [BYTES-1:0]  wr_be,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              rd_err,
    output logic              wr_err
);

    logic           rd_accept, wr_accept;
    logic           rd_run, wr_run;
    logic           rbeat, wbeat;
    logic [AW-1:0]  rd_word, wr_word;

    sqb4_burst_seq #(.IDX_W(IDX_W)) u_rd_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (rd_req),
        .idx       (rd_idx),
        .accept    (rd_accept),
        .beat_vld  (rd_run),
        .beat_word (rd_word),
        .rej_q     (rd_err)
    );

    sqb4_burst_seq #(.IDX_W(IDX_W)) u_wr_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (wr_req),
        .idx       (wr_idx),
        .accept    (wr_accept),
        .beat_vld  (wr_run),
        .beat_word (wr_word),
        .rej_q     (wr_err)
    );

    assign rbeat = rd_run && !rst;
    assign wbeat = wr_run && !rst;

    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        sqb4_lane #(.AW(AW)) u_lane (
            .clk   (clk),
            .we    (wbeat && wr_be[j]),
            .waddr (wr_word),
            .wd    (wr_data[j*BYTE_W +: BYTE_W]),
            .re    (rbeat),
            .raddr (rd_word),
            .rq    (rd_data[j*BYTE_W +: BYTE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rbeat;
        end
    end

endmodule

// File: rtl/sram_b4_chk.sv
module sram_b4_chk (
    input logic clk,
    input logic rst,
    input logic wr_req,
    input logic rd_accept,
    input logic wr_accept,
    input logic rd_valid,
    input logic rd_err,
    input logic wr_err
);

    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (rd_valid) begin
            run_q <= run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R3: first beat two cycles after acceptance
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        rd_accept |-> ##2 rd_valid);

    // R1: valid runs come in whole bursts of four
    a_r1_run_len: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> (run_q != 8'd0) && (run_q[1:0] == 2'd0));

    // R7: accepted reads are at least four cycles apart
    a_r7_rd_gap: assert property (@(posedge clk) disable iff (rst)
        rd_accept |-> !$past(rd_accept, 1) && !$past(rd_accept, 2) && !$past(rd_accept, 3));

    // R7: accepted writes are at least four cycles apart
    a_r7_wr_gap: assert property (@(posedge clk) disable iff (rst)
        wr_accept |-> !$past(wr_accept, 1) && !$past(wr_accept, 2) && !$past(wr_accept, 3));

    // R8: an ignored read only happens while a read burst is being delivered
    a_r8_rd_err: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_valid);

    // R8: a write error always follows a write command
    a_r8_wr_err: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_req));

    // R9: outputs quiet after a reset cycle
    a_r9_reset: assert property (@(posedge clk)
        rst |=> !rd_valid && !rd_err && !wr_err);

endmodule

bind sram_b4_core sram_b4_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .rd_accept (rd_accept),
    .wr_accept (wr_accept),
    .rd_valid  (rd_valid),
    .rd_err    (rd_err),
    .wr_err    (wr_err)
);

// File: tb/tb_sram_b4_core.sv
module tb_sram_b4_core;

    localparam int BYTES = 2;
    localparam int DW    = 18;
    localparam int DEPTH = 64;
    localparam int IW    = 4;
    localparam int NIDX  = DEPTH / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_req = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic          wr_req = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [BYTES-1:0] wr_be = '0;
    logic          rd_valid, rd_err, wr_err;
    logic [DW-1:0] rd_data;

    sram_b4_core #(.BYTES(BYTES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .rd_req(rd_req), .rd_idx(rd_idx),
        .wr_req(wr_req), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_err(rd_err), .wr_err(wr_err)
    );

    always #4 clk = ~clk;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    int            mw_left = 0, mr_left = 0;
    logic [IW-1:0] mw_base = '0, mr_base = '0;
    int            n_cmp = 0, n_bad = 0;
    int            cyc = 0;
    string         tag = "R9";

    task automatic cmp(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    // one beat cycle: model, clock edge, compare
    task automatic tick();
        logic          e_vld = 1'b0, e_rerr = 1'b0, e_werr = 1'b0;
        logic [DW-1:0] e_data = '0;
        logic [1:0]    k;
        bit            at_end;
        if (!rst) begin
            // write beat first so a same-cycle read sees it (R6)
            at_end = (mw_left <= 1);
            if (mw_left > 0) begin
                k = 2'(4 - mw_left);
                for (int j = 0; j < BYTES; j++)
                    if (wr_be[j]) ref_mem[{mw_base, k}][j*9 +: 9] = wr_data[j*9 +: 9];
                mw_left--;
            end
            if (wr_req) begin
                if (at_end) begin mw_left = 4; mw_base = wr_idx; end
                else e_werr = 1'b1;
            end
            at_end = (mr_left <= 1);
            if (mr_left > 0) begin
                k = 2'(4 - mr_left);
                e_vld  = 1'b1;
                e_data = ref_mem[{mr_base, k}];
                mr_left--;
            end
            if (rd_req) begin
                if (at_end) begin mr_left = 4; mr_base = rd_idx; end
                else e_rerr = 1'b1;
            end
        end else begin
            mw_left = 0;
            mr_left = 0;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        cmp("R3", "rd_valid", DW'(rd_valid), DW'(e_vld));
        cmp("R8", "rd_err", DW'(rd_err), DW'(e_rerr));
        cmp("R8", "wr_err", DW'(wr_err), DW'(e_werr));
        if (e_vld) cmp(tag, "rd_data", rd_data, e_data);
    endtask

    task automatic quiet();
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        wr_be   = '0;
        wr_data = DW'($urandom);
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) begin quiet(); tick(); end
    endtask

    task automatic read_all(string t);
        tag = t;
        for (int c = 0; c < NIDX * 4 + 6; c++) begin
            quiet();
            rd_req = (c % 4 == 0) && (c < NIDX * 4);
            rd_idx = IW'(c / 4);
            tick();
        end
    endtask

    initial begin
        @(negedge clk);
        // R9: reset state
        tag = "R9";
        rst = 1'b1;
        drain(3);
        rst = 1'b0;
        drain(2);

        // R1 R2 R7: fill every word with back-to-back full writes
        tag = "R1";
        for (int c = 0; c < NIDX * 4 + 4; c++) begin
            quiet();
            wr_req = (c % 4 == 0) && (c < NIDX * 4);
            wr_idx = IW'(c / 4);
            wr_be  = 2'b11;
            tick();
        end
        // R2 R3: back-to-back reads of every burst
        read_all("R2");

        // R4: masked beats, each beat its own enable pattern
        tag = "R4";
        for (int c = 0; c < 36; c++) begin
            quiet();
            wr_req = (c % 4 == 0) && (c < 32);
            wr_idx = IW'(c / 4 + 3);
            wr_be  = 2'(c);
            tick();
        end
        read_all("R4");

        // R6: read accepted 0..3 cycles after a write to the same burst
        tag = "R6";
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 12; c++) begin
                quiet();
                wr_req = (c == 0);
                wr_idx = IW'(5 + d);
                wr_be  = 2'($urandom);
                rd_req = (c == d);
                rd_idx = IW'(5 + d);
                tick();
            end
        end

        // R5: independent read and write in the same cycle, different bursts, back to back
        tag = "R5";
        for (int c = 0; c < 24; c++) begin
            quiet();
            wr_req = (c % 4 == 0) && (c < 16);
            wr_idx = IW'(c / 4);
            wr_be  = 2'b11;
            rd_req = wr_req;
            rd_idx = IW'(c / 4 + 8);
            tick();
        end

        // R7 R8: commands mid-burst are ignored and flagged
        tag = "R7";
        for (int c = 0; c < 10; c++) begin
            quiet();
            wr_req = (c < 4);
            wr_idx = IW'(c + 10);
            wr_be  = 2'b11;
            rd_req = (c < 4);
            rd_idx = IW'(c + 1);
            tick();
        end
        read_all("R7");

        // R1: random traffic on both ports
        tag = "R1";
        for (int c = 0; c < 600; c++) begin
            quiet();
            wr_req = ($urandom % 3 == 0);
            wr_idx = IW'($urandom);
            wr_be  = 2'($urandom);
            rd_req = ($urandom % 3 == 0);
            rd_idx = IW'($urandom);
            tick();
        end
        drain(6);

        // R9: reset in the middle of both bursts
        tag = "R9";
        quiet();
        wr_req = 1'b1; wr_idx = 4'd2; wr_be = 2'b11;
        rd_req = 1'b1; rd_idx = 4'd2;
        tick();
        quiet(); wr_be = 2'b11; tick();
        quiet(); wr_be = 2'b11; tick();
        rst = 1'b1;
        drain(2);
        rst = 1'b0;
        drain(6);
        read_all("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule